// File: doc/BRIEF.md
# Buffer-to-Core Word Copier

This block pairs a two-port on-chip word buffer with a small copy engine. The host CPU sees one flat address space split three ways: the buffer itself, a handful of engine registers, and a window onto the peripheral cores' register space. Software loads a source pointer, a destination pointer and a word count, chooses a direction, and sets the start bit. The engine then moves that many words on its own, either from the buffer out to a core's address window or from a core back into the buffer. The host keeps full access to the buffer while a copy runs, because the host and the engine each have their own memory port.

While the engine owns the core bus, host accesses to the core window are refused. They are not forwarded, they return a fixed error word, and they raise an error flag for one cycle. For long data, a restart option returns the destination pointer to its base every CHUNK words while the source pointer keeps going. A large buffer can then be pushed through a fixed-size core input window in equal slices.

The engine state machine has four states. ST_IDLE moves to ST_READ on an accepted start, or straight to ST_DONE if the count is zero. ST_READ always moves to ST_WRITE. ST_WRITE moves back to ST_READ while words remain, and to ST_DONE after the last word. ST_DONE always moves to ST_IDLE.

Top module: `xfer_top`

## Requirements
- R1: Host addresses with host_addr[9:8]=00 reach buffer word host_addr[7:0] through port A. A write takes effect at the clock edge. Read data appears on host_rdata in the cycle after the read strobe. This works both while idle and during a transfer.
- R2: Engine registers sit at host_addr[9:8]=01, with the offset in host_addr[2:0]: 0 source pointer, 1 destination pointer, 2 word count, 3 chunk length, 4 control, 5 status. Reads return the live value one cycle after the strobe. Writes to offsets 0 to 4 while busy are ignored.
- R3: With control bit1 (direction) at 0, word k of the copy is read from buffer[src+k] and written to core address dst+k. There is one core write every two cycles, and exactly count writes in total.
- R4: With direction 1, word k is read from core address src+k and written to buffer[dst+k], with exactly count words moved.
- R5: A start with count 0 completes (busy low, done high) with no core read or write strobe.
- R6: Status bit0 (busy) is 1 from the edge that accepts the start until the engine returns to ST_IDLE. Status bit1 (done) is set at the end of every copy, stays set, and is cleared by writing 1 to status bit1. After reset the status reads 0.
- R7: Writing control bit0 (start) while busy has no effect on the running copy.
- R8: While busy, a host access with host_addr[9] set produces no core strobe. A read returns 32'hDEAD_BEEF, and host_err is 1 in the cycle after the access.
- R9: While idle, host accesses with host_addr[9] set are forwarded to core address host_addr[7:0]. Read data from the core is returned one cycle later, and host_err stays 0.
- R10: With control bit2 (restart) set and a nonzero chunk length L, the destination pointer returns to its start value after every L words, while the source pointer keeps advancing.
- R11: Pointers wrap modulo the 256-word depth. After completion, the pointer registers read back start+count (mod 256), or the rewound value under R10, and the count reads 0.
- R12: If a host write and an engine write hit the same buffer word in the same cycle, the engine's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 10 | Host word address (region in bits 9:8) |
| host_wdata | input | 32 | Host write data |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_rdata | output | 32 | Host read data, valid the cycle after host_re |
| host_err | output | 1 | Refused core access flag, one cycle after the access |
| core_addr | output | 8 | Core bus address |
| core_wdata | output | 32 | Core bus write data |
| core_we | output | 1 | Core bus write strobe |
| core_re | output | 1 | Core bus read strobe |
| core_rdata | input | 32 | Core read data, valid the cycle after core_re |

## Verification
The two functions that can land in the same cycle are the host's buffer write on port A and the engine's buffer write on port B in the final ST_WRITE of a core-to-buffer copy. The bench sets up a one-word copy and times a host write to the same destination word so that it is sampled at the same edge as the engine's write, two edges after the start is accepted. It then reads the word back and expects the core's value, not the host's. The other overlap tested is host traffic during a copy: buffer reads, register writes, a repeated start and refused core accesses are issued while busy, and the result is judged by the exact number of core strobes and the final pointer values.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } xfer_state_t;

    typedef enum logic [1:0] {
        SEL_MEM  = 2'd0,
        SEL_REG  = 2'd1,
        SEL_CORE = 2'd2,
        SEL_ERR  = 2'd3
    } rsel_t;

    localparam logic [2:0] REG_SRC   = 3'd0;
    localparam logic [2:0] REG_DST   = 3'd1;
    localparam logic [2:0] REG_CNT   = 3'd2;
    localparam logic [2:0] REG_CHUNK = 3'd3;
    localparam logic [2:0] REG_CTRL  = 3'd4;
    localparam logic [2:0] REG_STAT  = 3'd5;

    localparam int CTRL_START   = 0;
    localparam int CTRL_DIR     = 1;
    localparam int CTRL_RESTART = 2;
    localparam int STAT_BUSY    = 0;
    localparam int STAT_DONE    = 1;
endpackage

// File: rtl/xfer_dpram.sv
module xfer_dpram #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Port B is written last so that it wins a same-address collision.
    always_ff @(posedge clk) begin
        if (a_en) begin
            if (a_we) mem[a_addr] <= a_wdata;
            a_rdata <= mem[a_addr];
        end
        if (b_we) mem[b_addr] <= b_wdata;
        b_rdata <= mem[b_addr];
    end

    assert_port_b_wins_R12: assert property (@(posedge clk)
        (a_en && a_we && b_we && a_addr == b_addr) |=> mem[$past(b_addr)] == $past(b_wdata));
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
    import xfer_pkg::*;
#(
    parameter int DW = 32,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          busy,
    output logic [PW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [PW-1:0] c_addr,
    output logic          c_we,
    output logic          c_re,
    output logic [DW-1:0] c_wdata,
    input  logic [DW-1:0] c_rdata
);
    localparam int CW = PW + 1;

    xfer_state_t state_q, state_d;
    logic [PW-1:0] src_q, dst_q, dst_base_q;
    logic [CW-1:0] cnt_q, chunk_q, chunk_pos_q;
    logic          dir_q, restart_q, done_q;
    logic          cfg_we, start_ok, restart_hit, last_word;

    assign cfg_we      = reg_we && (state_q == ST_IDLE);
    assign start_ok    = cfg_we && (reg_addr == REG_CTRL) && reg_wdata[CTRL_START];
    assign restart_hit = restart_q && (chunk_q != '0) && (chunk_pos_q + CW'(1) == chunk_q);
    assign last_word   = (cnt_q == CW'(1));
    assign busy        = (state_q != ST_IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_ok) state_d = (cnt_q == '0) ? ST_DONE : ST_READ;
            ST_READ:  state_d = ST_WRITE;
            ST_WRITE: state_d = last_word ? ST_DONE : ST_READ;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    // Registers and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q       <= '0;
            dst_q       <= '0;
            dst_base_q  <= '0;
            cnt_q       <= '0;
            chunk_q     <= '0;
            chunk_pos_q <= '0;
            dir_q       <= 1'b0;
            restart_q   <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            if (cfg_we) begin
                case (reg_addr)
                    REG_SRC:   src_q   <= reg_wdata[PW-1:0];
                    REG_DST:   dst_q   <= reg_wdata[PW-1:0];
                    REG_CNT:   cnt_q   <= reg_wdata[CW-1:0];
                    REG_CHUNK: chunk_q <= reg_wdata[CW-1:0];
                    REG_CTRL: begin
                        dir_q     <= reg_wdata[CTRL_DIR];
                        restart_q <= reg_wdata[CTRL_RESTART];
                    end
                    default: ;
                endcase
            end
            if (start_ok) begin
                dst_base_q  <= dst_q;
                chunk_pos_q <= '0;
            end
            if (state_q == ST_WRITE) begin
                src_q <= src_q + PW'(1);
                cnt_q <= cnt_q - CW'(1);
                if (restart_hit) begin
                    dst_q       <= dst_base_q;
                    chunk_pos_q <= '0;
                end else begin
                    dst_q       <= dst_q + PW'(1);
                    chunk_pos_q <= chunk_pos_q + CW'(1);
                end
            end
            if (state_q == ST_DONE)
                done_q <= 1'b1;
            else if (reg_we && reg_addr == REG_STAT && reg_wdata[STAT_DONE])
                done_q <= 1'b0;
        end
    end

    // Bus outputs
    always_comb begin
        mem_addr  = dir_q ? dst_q : src_q;
        mem_we    = 1'b0;
        mem_wdata = c_rdata;
        c_addr    = dir_q ? src_q : dst_q;
        c_we      = 1'b0;
        c_re      = 1'b0;
        c_wdata   = mem_rdata;
        unique case (state_q)
            ST_READ:  c_re = dir_q;
            ST_WRITE: begin
                mem_we = dir_q;
                c_we   = !dir_q;
            end
            ST_IDLE, ST_DONE: ;
        endcase
    end

    // Register read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_SRC:   reg_rdata = DW'(src_q);
            REG_DST:   reg_rdata = DW'(dst_q);
            REG_CNT:   reg_rdata = DW'(cnt_q);
            REG_CHUNK: reg_rdata = DW'(chunk_q);
            REG_CTRL:  reg_rdata = DW'({restart_q, dir_q, 1'b0});
            REG_STAT:  reg_rdata = DW'({done_q, busy});
            default:   reg_rdata = '0;
        endcase
    end

    assert_read_then_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_READ |=> state_q == ST_WRITE);
    assert_zero_count_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ok && cnt_q == '0) |=> state_q == ST_DONE);
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q != ST_DONE) |=> $stable(dst_base_q));
    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !(reg_we && reg_addr == REG_STAT && reg_wdata[STAT_DONE])) |=> done_q);
endmodule

// File: rtl/xfer_host_if.sv
module xfer_host_if
    import xfer_pkg::*;
#(
    parameter int DW  = 32,
    parameter int PW  = 8,
    parameter int HAW = PW + 2,
    parameter logic [DW-1:0] ERR_WORD = 32'hDEAD_BEEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [HAW-1:0] h_addr,
    input  logic [DW-1:0]  h_wdata,
    input  logic           h_we,
    input  logic           h_re,
    output logic [DW-1:0]  h_rdata,
    output logic           h_err,
    input  logic           busy,
    output logic           ma_en,
    output logic           ma_we,
    output logic [PW-1:0]  ma_addr,
    output logic [DW-1:0]  ma_wdata,
    input  logic [DW-1:0]  ma_rdata,
    output logic           reg_we,
    output logic [2:0]     reg_addr,
    output logic [DW-1:0]  reg_wdata,
    input  logic [DW-1:0]  reg_rdata,
    output logic [PW-1:0]  hc_addr,
    output logic           hc_we,
    output logic           hc_re,
    output logic [DW-1:0]  hc_wdata,
    input  logic [DW-1:0]  c_rdata
);
    logic    in_mem, in_reg, in_core, acc, blocked;
    rsel_t   sel_q;
    logic [DW-1:0] reg_q;
    logic    err_q;

    assign acc     = h_we || h_re;
    assign in_mem  = (h_addr[HAW-1:HAW-2] == 2'b00);
    assign in_reg  = (h_addr[HAW-1:HAW-2] == 2'b01);
    assign in_core = h_addr[HAW-1];
    assign blocked = acc && in_core && busy;

    assign ma_en     = acc && in_mem;
    assign ma_we     = h_we && in_mem;
    assign ma_addr   = h_addr[PW-1:0];
    assign ma_wdata  = h_wdata;
    assign reg_we    = h_we && in_reg;
    assign reg_addr  = h_addr[2:0];
    assign reg_wdata = h_wdata;
    assign hc_addr   = h_addr[PW-1:0];
    assign hc_wdata  = h_wdata;
    assign hc_we     = h_we && in_core && !busy;
    assign hc_re     = h_re && in_core && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SEL_MEM;
            reg_q <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= blocked;
            if (h_re) begin
                if (in_reg) reg_q <= reg_rdata;
                if (in_mem)       sel_q <= SEL_MEM;
                else if (in_reg)  sel_q <= SEL_REG;
                else if (busy)    sel_q <= SEL_ERR;
                else              sel_q <= SEL_CORE;
            end
        end
    end

    always_comb begin
        unique case (sel_q)
            SEL_MEM:  h_rdata = ma_rdata;
            SEL_REG:  h_rdata = reg_q;
            SEL_CORE: h_rdata = c_rdata;
            SEL_ERR:  h_rdata = ERR_WORD;
        endcase
    end
    assign h_err = err_q;

    assert_lockout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(hc_we || hc_re));
    assert_err_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> h_err);
    assert_no_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !busy) |=> !h_err);
endmodule

// File: rtl/xfer_top.sv
module xfer_top
    import xfer_pkg::*;
#(
    parameter int DW     = 32,
    parameter int MEM_AW = 8,
    parameter int HAW    = MEM_AW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HAW-1:0]    host_addr,
    input  logic [DW-1:0]     host_wdata,
    input  logic              host_we,
    input  logic              host_re,
    output logic [DW-1:0]     host_rdata,
    output logic              host_err,
    output logic [MEM_AW-1:0] core_addr,
    output logic [DW-1:0]     core_wdata,
    output logic              core_we,
    output logic              core_re,
    input  logic [DW-1:0]     core_rdata
);
    logic              busy;
    logic              ma_en, ma_we;
    logic [MEM_AW-1:0] ma_addr;
    logic [DW-1:0]     ma_wdata, ma_rdata;
    logic              reg_we;
    logic [2:0]        reg_addr;
    logic [DW-1:0]     reg_wdata, reg_rdata;
    logic [MEM_AW-1:0] hc_addr, ec_addr, mb_addr;
    logic              hc_we, hc_re, ec_we, ec_re, mb_we;
    logic [DW-1:0]     hc_wdata, ec_wdata, mb_wdata, mb_rdata;

    xfer_host_if #(.DW(DW), .PW(MEM_AW), .HAW(HAW)) u_host (
        .clk(clk), .rst_n(rst_n),
        .h_addr(host_addr), .h_wdata(host_wdata), .h_we(host_we), .h_re(host_re),
        .h_rdata(host_rdata), .h_err(host_err), .busy(busy),
        .ma_en(ma_en), .ma_we(ma_we), .ma_addr(ma_addr), .ma_wdata(ma_wdata), .ma_rdata(ma_rdata),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hc_addr(hc_addr), .hc_we(hc_we), .hc_re(hc_re), .hc_wdata(hc_wdata), .c_rdata(core_rdata)
    );

    xfer_engine #(.DW(DW), .PW(MEM_AW)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy),
        .mem_addr(mb_addr), .mem_we(mb_we), .mem_wdata(mb_wdata), .mem_rdata(mb_rdata),
        .c_addr(ec_addr), .c_we(ec_we), .c_re(ec_re), .c_wdata(ec_wdata), .c_rdata(core_rdata)
    );

    xfer_dpram #(.DW(DW), .AW(MEM_AW)) u_ram (
        .clk(clk),
        .a_en(ma_en), .a_we(ma_we), .a_addr(ma_addr), .a_wdata(ma_wdata), .a_rdata(ma_rdata),
        .b_we(mb_we), .b_addr(mb_addr), .b_wdata(mb_wdata), .b_rdata(mb_rdata)
    );

    assign core_addr  = busy ? ec_addr  : hc_addr;
    assign core_wdata = busy ? ec_wdata : hc_wdata;
    assign core_we    = busy ? ec_we    : hc_we;
    assign core_re    = busy ? ec_re    : hc_re;
endmodule

// File: tb/xfer_top_bench.sv
module xfer_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_we = 1'b0, host_re = 1'b0;
    logic [31:0] host_rdata;
    logic        host_err;
    logic [7:0]  core_addr;
    logic [31:0] core_wdata, core_rdata;
    logic        core_we, core_re;

    int tests = 0, fails = 0;
    int cyc = 0, we_cnt = 0, re_cnt = 0, first_we = -1, last_we = -1;
    logic [31:0] core_mem [256];
    logic [31:0] rd;
    logic        rerr;

    localparam logic [9:0] RB = 10'h100, CB = 10'h200;

    always #2.5 clk = ~clk;

    xfer_top u_xfer_top (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_we(host_we), .host_re(host_re),
        .host_rdata(host_rdata), .host_err(host_err),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_we(core_we), .core_re(core_re),
        .core_rdata(core_rdata)
    );

    // Core register space model: read data one cycle after strobe
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (core_we) begin
            core_mem[core_addr] = core_wdata;
            if (first_we < 0) first_we = cyc;
            last_we = cyc;
            we_cnt = we_cnt + 1;
        end
        if (core_re) begin
            core_rdata <= core_mem[core_addr];
            re_cnt = re_cnt + 1;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hw(logic [9:0] a, logic [31:0] d);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hr(logic [9:0] a);
        host_addr = a; host_re = 1'b1;
        @(negedge clk);
        host_re = 1'b0;
        rd = host_rdata; rerr = host_err;
    endtask

    task automatic clr_mon();
        we_cnt = 0; re_cnt = 0; first_we = -1; last_we = -1;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000; i++) begin
            hr(RB + 5);
            if (rd[0] == 1'b0) break;
        end
    endtask

    task automatic t_reset();
        hr(RB + 5); chk("R6 status after reset", rd, 32'h0);
        chk("R9 no error after reset", {31'b0, rerr}, 32'h0);
    endtask

    task automatic t_mem_rw();
        hw(10'h003, 32'hA5A5_0003);
        hw(10'h004, 32'h5A5A_0004);
        hr(10'h003); chk("R1 buffer readback 3", rd, 32'hA5A5_0003);
        hr(10'h004); chk("R1 buffer readback 4", rd, 32'h5A5A_0004);
    endtask

    task automatic t_core_fwd();
        clr_mon();
        hw(CB + 10'h05, 32'h1111_2222);
        chk("R9 forwarded write", core_mem[5], 32'h1111_2222);
        hr(CB + 10'h05);
        chk("R9 forwarded read", rd, 32'h1111_2222);
        chk("R9 no error idle", {31'b0, rerr}, 32'h0);
    endtask

    task automatic t_m2c();
        for (int i = 0; i < 6; i++) hw(10'(10 + i), 32'hC000_0000 + i);
        core_mem[8'h2A] = 32'h0BAD_0BAD;
        hw(RB + 0, 32'd10); hw(RB + 1, 32'h20); hw(RB + 2, 32'd6);
        clr_mon();
        hw(RB + 4, 32'h1);
        hr(RB + 5); chk("R6 busy during copy", rd & 32'h1, 32'h1);
        hw(RB + 0, 32'h77);
        hw(RB + 4, 32'h1);
        hr(CB + 10'h2A); chk("R8 blocked read value", rd, 32'hDEAD_BEEF);
        chk("R8 error flag on read", {31'b0, rerr}, 32'h1);
        hw(CB + 10'h2A, 32'h1234_5678);
        chk("R8 error flag on write", {31'b0, host_err}, 32'h1);
        hr(10'd11); chk("R1 buffer read while busy", rd, 32'hC000_0001);
        wait_idle();
        for (int i = 0; i < 6; i++) chk("R3 core data", core_mem[8'h20 + i], 32'hC000_0000 + i);
        chk("R3 exact write count", we_cnt, 6);
        chk("R3 two cycles per word", last_we - first_we, 10);
        chk("R8 no core read strobe", re_cnt, 0);
        chk("R8 blocked write dropped", core_mem[8'h2A], 32'h0BAD_0BAD);
        hr(RB + 0); chk("R2 R11 src final (busy write ignored)", rd, 32'd16);
        hr(RB + 1); chk("R11 dst final", rd, 32'h26);
        hr(RB + 2); chk("R11 count final", rd, 32'h0);
        hr(RB + 5); chk("R6 done set", rd, 32'h2);
        hw(RB + 5, 32'h2);
        hr(RB + 5); chk("R6 done cleared", rd, 32'h0);
    endtask

    task automatic t_c2m();
        for (int i = 0; i < 3; i++) core_mem[8'h40 + i] = 32'hD000_0000 + i;
        hw(RB + 0, 32'h40); hw(RB + 1, 32'h60); hw(RB + 2, 32'd3);
        clr_mon();
        hw(RB + 4, 32'h3);
        wait_idle();
        for (int i = 0; i < 3; i++) begin
            hr(10'(8'h60 + i)); chk("R4 buffer data", rd, 32'hD000_0000 + i);
        end
        chk("R4 read strobes", re_cnt, 3);
        chk("R4 no core writes", we_cnt, 0);
        hw(RB + 5, 32'h2);
    endtask

    task automatic t_zero();
        hw(RB + 2, 32'd0);
        clr_mon();
        hw(RB + 4, 32'h1);
        wait_idle();
        hr(RB + 5); chk("R5 done for zero count", rd, 32'h2);
        chk("R5 no strobes", we_cnt + re_cnt, 0);
        hw(RB + 5, 32'h2);
    endtask

    task automatic t_restart();
        for (int i = 0; i < 6; i++) hw(10'(8'h80 + i), 32'hE000_0000 + i);
        hw(RB + 0, 32'h80); hw(RB + 1, 32'h30); hw(RB + 2, 32'd6); hw(RB + 3, 32'd2);
        clr_mon();
        hw(RB + 4, 32'h5);
        wait_idle();
        chk("R10 slot 0 last chunk", core_mem[8'h30], 32'hE000_0004);
        chk("R10 slot 1 last chunk", core_mem[8'h31], 32'hE000_0005);
        chk("R10 write count", we_cnt, 6);
        hr(RB + 1); chk("R10 dst rewound", rd, 32'h30);
        hr(RB + 0); chk("R10 src advanced", rd, 32'h86);
        hw(RB + 5, 32'h2);
    endtask

    task automatic t_wrap();
        hw(10'h0FE, 32'hF0); hw(10'h0FF, 32'hF1); hw(10'h000, 32'hF2);
        hw(RB + 0, 32'hFE); hw(RB + 1, 32'h50); hw(RB + 2, 32'd3);
        hw(RB + 4, 32'h1);
        wait_idle();
        chk("R11 wrap word 2", core_mem[8'h52], 32'hF2);
        hr(RB + 0); chk("R11 src wrapped", rd, 32'h01);
        hw(RB + 5, 32'h2);
    endtask

    task automatic t_collide();
        core_mem[8'h70] = 32'h7777_AAAA;
        hw(RB + 0, 32'h70); hw(RB + 1, 32'h90); hw(RB + 2, 32'd1);
        hw(RB + 4, 32'h3);
        @(negedge clk);
        hw(10'h090, 32'h5555_5555);
        wait_idle();
        hr(10'h090); chk("R12 engine write wins", rd, 32'h7777_AAAA);
        hw(RB + 5, 32'h2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        core_rdata = '0;
        for (int i = 0; i < 256; i++) core_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mem_rw();
        t_core_fwd();
        t_m2c();
        t_c2m();
        t_zero();
        t_restart();
        t_wrap();
        t_collide();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule